// File: doc/BRIEF.md
# Partitioned Physical Register File

This block holds the physical registers of an out-of-order core in one storage structure. The registers are addressed through a single flat index, and that index is divided at a parameterised boundary. Every index below the integer count selects an entry of the integer bank. The indices from that count up to the total select the floating-point bank, and the block subtracts the integer count from such an index to find the entry inside the floating-point bank. A caller never needs to know where the boundary lies, because a classification port reports the bank of any index it is given.

Every read port and every write port carries an index, a kind and data. The kind says how the caller means to use the entry: as an integer, as a floating-point number, or as the raw bits of a floating-point entry. The number view and the bit view point at the same stored bits. An access whose kind does not fit the bank of its index raises an error, and so does an index at or beyond the total count. An erroneous write changes nothing.

Integer writes to the zero register are dropped. A parameter decides whether writes to the same bank-local offset in the floating-point bank are dropped as well. Reads are combinational. Writes take effect on the rising clock edge.

Top module: `prf_unified`

## Requirements
- R1: `cls_is_int` is high exactly when `cls_idx` < NUM_INT. `cls_is_fp` is high exactly when NUM_INT <= `cls_idx` < NUM_INT+NUM_FP. Both are low for larger indices.
- R2: Kind codes are 0 for integer, 1 for floating-point value, 2 for floating-point raw bits, and 3 is reserved. An access is in error when its kind is 3, when its index is at or beyond NUM_INT+NUM_FP, when it uses kind 1 or 2 on an integer index, or when it uses kind 0 on a floating-point index. `rd_err` reports this combinationally for each read port. `wr_err` reports it for each write port only while that port's enable is high.
- R3: A write in error stores nothing, so later reads of every entry are unchanged. A read in error returns all-zero data.
- R4: A floating-point index i reaches bank entry i-NUM_INT. A value written with kind 1 reads back identically with kind 2, and a value written with kind 2 reads back identically with kind 1.
- R5: Read data is combinational from the stored state. A write becomes visible from the cycle after its rising edge, so a read of the same entry in the write's own cycle returns the old value.
- R6: An integer write to index ZERO_IDX is discarded, and that entry always reads zero.
- R7: A floating-point write to bank-local offset ZERO_IDX (index NUM_INT+ZERO_IDX) is stored when FP_ZERO_EN is 0. It is discarded, and the entry reads zero, when FP_ZERO_EN is 1.
- R8: When several write ports write the same entry without error in one cycle, the highest-numbered port's data is stored.
- R9: While `rst` is high at a rising edge, every entry is cleared to zero.
- R10: Each read port returns the entry named by its own index, independently of the other read ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears every entry |
| rd_idx | input | N_RD*IW | Flat index for each read port, with port p in bits [p*IW +: IW] |
| rd_kind | input | N_RD*2 | Access kind for each read port |
| rd_data | output | N_RD*XLEN | Read data for each read port |
| rd_err | output | N_RD | Per-port flag for a read class or range error |
| wr_en | input | N_WR | Per-port write enable |
| wr_idx | input | N_WR*IW | Flat index for each write port |
| wr_kind | input | N_WR*2 | Access kind for each write port |
| wr_data | input | N_WR*XLEN | Write data for each write port |
| wr_err | output | N_WR | Per-port flag for a write class or range error, while enabled |
| cls_idx | input | IW | Index to classify |
| cls_is_int | output | 1 | `cls_idx` is an integer register |
| cls_is_fp | output | 1 | `cls_idx` is a floating-point register |

## Verification
Random traffic almost never lands on the hardest situation for this block, which is a same-cycle collision between write ports on one entry. In the variant that also tests the floating-point zero offset, that collision overlaps with suppression of the zero register. The bench therefore forces these cases in directed cycles. It aims both write ports at the same integer entry, and it aims writes at index NUM_INT+ZERO_IDX. Two instances, one for each setting of FP_ZERO_EN, share every input. Each instance is compared against its own behavioural model on every cycle, and a long run of biased random traffic follows: indices are drawn from a small window so that entries are written and then read back often, and wrong kinds and out-of-range indices are mixed in.

// File: rtl/prf_pkg.sv
package prf_pkg;

  typedef enum logic [1:0] {
    PK_INT = 2'd0,
    PK_FPV = 2'd1,
    PK_FPB = 2'd2,
    PK_RSV = 2'd3
  } prf_kind_e;

  // True when the access kind fits the bank that the index falls in
  function automatic logic kind_fits(input logic is_int, input logic is_fp,
                                     input logic [1:0] kind);
    logic ok;
    ok = 1'b0;
    if (kind != PK_RSV) begin
      if (is_int) ok = (kind == PK_INT);
      else if (is_fp) ok = (kind != PK_INT);
    end
    return ok;
  endfunction

endpackage

// File: rtl/prf_classify.sv
module prf_classify #(
  parameter int NUM_INT = 24,
  parameter int NUM_FP  = 20,
  parameter int IW      = 6
) (
  input  logic [IW-1:0] idx,
  output logic          is_int,
  output logic          is_fp,
  output logic [IW-1:0] off
);
  localparam int TOTAL = NUM_INT + NUM_FP;

  function automatic logic in_int(input logic [IW-1:0] i);
    return 32'(i) < NUM_INT;
  endfunction

  function automatic logic in_fp(input logic [IW-1:0] i);
    return (32'(i) >= NUM_INT) && (32'(i) < TOTAL);
  endfunction

  // Bank-local offset: remove the floating-point base
  function automatic logic [IW-1:0] fp_local(input logic [IW-1:0] i);
    return IW'(32'(i) - NUM_INT);
  endfunction

  always_comb begin
    is_int = in_int(idx);
    is_fp  = in_fp(idx);
    if (is_int)     off = idx;
    else if (is_fp) off = fp_local(idx);
    else            off = '0;
  end
endmodule

// File: rtl/prf_access_check.sv
module prf_access_check
  import prf_pkg::*;
(
  input  logic       en,
  input  logic       is_int,
  input  logic       is_fp,
  input  logic [1:0] kind,
  output logic       err
);
  always_comb err = en & ~kind_fits(is_int, is_fp, kind);
endmodule

// File: rtl/prf_bank.sv
module prf_bank #(
  parameter int DEPTH         = 24,
  parameter int XLEN          = 64,
  parameter int AW            = 6,
  parameter int N_RD          = 2,
  parameter int N_WR          = 2,
  parameter int ZERO_IDX      = 0,
  parameter bit SUPPRESS_ZERO = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_WR-1:0]      we,
  input  logic [N_WR*AW-1:0]   waddr,
  input  logic [N_WR*XLEN-1:0] wdata,
  input  logic [N_RD*AW-1:0]   raddr,
  output logic [N_RD*XLEN-1:0] rdata
);
  logic [XLEN-1:0] mem [DEPTH];
  logic [N_WR-1:0] sup_hit;   // write dropped at the zero entry
  logic [N_WR-1:0] store;     // write actually stored

  genvar g;
  generate
    for (g = 0; g < N_WR; g++) begin : g_wr
      always_comb begin
        sup_hit[g] = we[g] && SUPPRESS_ZERO &&
                     (32'(waddr[g*AW +: AW]) == ZERO_IDX);
        store[g]   = we[g] && !sup_hit[g] &&
                     (32'(waddr[g*AW +: AW]) < DEPTH);
      end
    end
    for (g = 0; g < N_RD; g++) begin : g_rd
      always_comb begin
        if (32'(raddr[g*AW +: AW]) < DEPTH)
          rdata[g*XLEN +: XLEN] = mem[raddr[g*AW +: AW]];
        else
          rdata[g*XLEN +: XLEN] = '0;
      end
    end
  endgenerate

  // Ascending port order: the highest port writing an entry wins
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
    end else begin
      for (int p = 0; p < N_WR; p++)
        if (store[p]) mem[waddr[p*AW +: AW]] <= wdata[p*XLEN +: XLEN];
    end
  end

  generate
    if (SUPPRESS_ZERO && ZERO_IDX < DEPTH) begin : g_zchk
      AST_ZERO_KEPT: assert property (@(posedge clk) disable iff (rst)
        (|sup_hit) |=> (mem[ZERO_IDX] == $past(mem[ZERO_IDX]))); // R6
      AST_ZERO_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        mem[ZERO_IDX] == '0); // R7
    end
  endgenerate
endmodule

// File: rtl/prf_unified.sv
module prf_unified
  import prf_pkg::*;
#(
  parameter int NUM_INT    = 24,
  parameter int NUM_FP     = 20,
  parameter int XLEN       = 64,
  parameter int N_RD       = 2,
  parameter int N_WR       = 2,
  parameter int ZERO_IDX   = 0,
  parameter bit FP_ZERO_EN = 1'b0,
  parameter int IW         = $clog2(NUM_INT + NUM_FP)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N_RD*IW-1:0]   rd_idx,
  input  logic [N_RD*2-1:0]    rd_kind,
  output logic [N_RD*XLEN-1:0] rd_data,
  output logic [N_RD-1:0]      rd_err,
  input  logic [N_WR-1:0]      wr_en,
  input  logic [N_WR*IW-1:0]   wr_idx,
  input  logic [N_WR*2-1:0]    wr_kind,
  input  logic [N_WR*XLEN-1:0] wr_data,
  output logic [N_WR-1:0]      wr_err,
  input  logic [IW-1:0]        cls_idx,
  output logic                 cls_is_int,
  output logic                 cls_is_fp
);
  logic [N_RD-1:0]      rd_is_int, rd_is_fp;
  logic [N_RD*IW-1:0]   rd_off;
  logic [N_RD*XLEN-1:0] int_rdata, fp_rdata;
  logic [N_WR-1:0]      wr_is_int, wr_is_fp;
  logic [N_WR*IW-1:0]   wr_off;
  logic [N_WR-1:0]      int_we, fp_we;
  logic [IW-1:0]        cls_off;

  prf_classify #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IW(IW)) u_cls (
    .idx(cls_idx), .is_int(cls_is_int), .is_fp(cls_is_fp), .off(cls_off));

  genvar g;
  generate
    for (g = 0; g < N_RD; g++) begin : g_rp
      prf_classify #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IW(IW)) u_c (
        .idx(rd_idx[g*IW +: IW]), .is_int(rd_is_int[g]), .is_fp(rd_is_fp[g]),
        .off(rd_off[g*IW +: IW]));
      prf_access_check u_k (
        .en(1'b1), .is_int(rd_is_int[g]), .is_fp(rd_is_fp[g]),
        .kind(rd_kind[g*2 +: 2]), .err(rd_err[g]));
      always_comb begin
        if (rd_err[g])       rd_data[g*XLEN +: XLEN] = '0;
        else if (rd_is_int[g]) rd_data[g*XLEN +: XLEN] = int_rdata[g*XLEN +: XLEN];
        else                 rd_data[g*XLEN +: XLEN] = fp_rdata[g*XLEN +: XLEN];
      end
      AST_RD_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_err[g] |-> (rd_data[g*XLEN +: XLEN] == '0)); // R3
    end
    for (g = 0; g < N_WR; g++) begin : g_wp
      prf_classify #(.NUM_INT(NUM_INT), .NUM_FP(NUM_FP), .IW(IW)) u_c (
        .idx(wr_idx[g*IW +: IW]), .is_int(wr_is_int[g]), .is_fp(wr_is_fp[g]),
        .off(wr_off[g*IW +: IW]));
      prf_access_check u_k (
        .en(wr_en[g]), .is_int(wr_is_int[g]), .is_fp(wr_is_fp[g]),
        .kind(wr_kind[g*2 +: 2]), .err(wr_err[g]));
      always_comb begin
        int_we[g] = wr_en[g] && !wr_err[g] && wr_is_int[g];
        fp_we[g]  = wr_en[g] && !wr_err[g] && wr_is_fp[g];
      end
      AST_ERR_NO_WE: assert property (@(posedge clk) disable iff (rst)
        wr_err[g] |-> !(int_we[g] || fp_we[g])); // R3
      AST_SINGLE_BANK: assert property (@(posedge clk) disable iff (rst)
        !(int_we[g] && fp_we[g])); // R4
    end
  endgenerate

  prf_bank #(.DEPTH(NUM_INT), .XLEN(XLEN), .AW(IW), .N_RD(N_RD), .N_WR(N_WR),
             .ZERO_IDX(ZERO_IDX), .SUPPRESS_ZERO(1'b1)) u_int_bank (
    .clk(clk), .rst(rst), .we(int_we), .waddr(wr_off), .wdata(wr_data),
    .raddr(rd_off), .rdata(int_rdata));

  prf_bank #(.DEPTH(NUM_FP), .XLEN(XLEN), .AW(IW), .N_RD(N_RD), .N_WR(N_WR),
             .ZERO_IDX(ZERO_IDX), .SUPPRESS_ZERO(FP_ZERO_EN)) u_fp_bank (
    .clk(clk), .rst(rst), .we(fp_we), .waddr(wr_off), .wdata(wr_data),
    .raddr(rd_off), .rdata(fp_rdata));

  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cls_is_int && cls_is_fp)); // R1
  AST_CLASS_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    cls_is_fp |-> (32'(cls_off) < NUM_FP)); // R4
endmodule

// File: tb/prf_unified_tb.sv
module prf_unified_tb;
  localparam int NI = 24, NF = 20, TOT = NI + NF, IW = 6, XL = 64;
  localparam int NR = 2, NW = 2, ZI = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [NR*IW-1:0] rd_idx = '0;
  logic [NR*2-1:0]  rd_kind = '0;
  logic [NW-1:0]    wr_en = '0;
  logic [NW*IW-1:0] wr_idx = '0;
  logic [NW*2-1:0]  wr_kind = '0;
  logic [NW*XL-1:0] wr_data = '0;
  logic [IW-1:0]    cls_idx = '0;

  logic [NR*XL-1:0] rdd [2];
  logic [NR-1:0]    rde [2];
  logic [NW-1:0]    wre [2];
  logic             cli [2];
  logic             clf [2];

  prf_unified #(.NUM_INT(NI), .NUM_FP(NF), .XLEN(XL), .N_RD(NR), .N_WR(NW),
                .ZERO_IDX(ZI), .FP_ZERO_EN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_kind(rd_kind), .rd_data(rdd[0]),
    .rd_err(rde[0]), .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
    .wr_data(wr_data), .wr_err(wre[0]), .cls_idx(cls_idx),
    .cls_is_int(cli[0]), .cls_is_fp(clf[0]));

  prf_unified #(.NUM_INT(NI), .NUM_FP(NF), .XLEN(XL), .N_RD(NR), .N_WR(NW),
                .ZERO_IDX(ZI), .FP_ZERO_EN(1'b1)) u_dut_z (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .rd_kind(rd_kind), .rd_data(rdd[1]),
    .rd_err(rde[1]), .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
    .wr_data(wr_data), .wr_err(wre[1]), .cls_idx(cls_idx),
    .cls_is_int(cli[1]), .cls_is_fp(clf[1]));

  // Behavioural model: integer bank shared, one floating-point bank per variant
  logic [XL-1:0] m_int [NI];
  logic [XL-1:0] m_fp  [2][NF];

  int n_run = 0, n_fail = 0;

  function automatic bit is_bad(input int idx, input int kind);
    if (kind == 3 || idx >= TOT) return 1;
    if (idx < NI) return kind != 0;
    return kind == 0;
  endfunction

  function automatic logic [XL-1:0] model_read(input int d, input int idx, input int kind);
    if (is_bad(idx, kind)) return '0;
    if (idx < NI) return m_int[idx];
    return m_fp[d][idx - NI];
  endfunction

  task automatic chk(input string tag, input logic [XL-1:0] got, input logic [XL-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t got=%h exp=%h", tag, $time, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < NR; p++) begin
        int ix, kd;
        ix = int'(rd_idx[p*IW +: IW]);
        kd = int'(rd_kind[p*2 +: 2]);
        chk(tag, rdd[d][p*XL +: XL], model_read(d, ix, kd));
        chk("R2 rd_err", XL'(rde[d][p]), XL'(is_bad(ix, kd)));
      end
      for (int p = 0; p < NW; p++)
        chk("R2 wr_err", XL'(wre[d][p]),
            XL'(wr_en[p] && is_bad(int'(wr_idx[p*IW +: IW]), int'(wr_kind[p*2 +: 2]))));
      chk("R1 is_int", XL'(cli[d]), XL'(int'(cls_idx) < NI));
      chk("R1 is_fp",  XL'(clf[d]), XL'(int'(cls_idx) >= NI && int'(cls_idx) < TOT));
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int e = 0; e < NI; e++) m_int[e] = '0;
      for (int d = 0; d < 2; d++) for (int e = 0; e < NF; e++) m_fp[d][e] = '0;
    end else begin
      for (int p = 0; p < NW; p++) begin
        int ix, kd;
        ix = int'(wr_idx[p*IW +: IW]);
        kd = int'(wr_kind[p*2 +: 2]);
        if (wr_en[p] && !is_bad(ix, kd)) begin
          if (ix < NI) begin
            if (ix != ZI) m_int[ix] = wr_data[p*XL +: XL];
          end else begin
            m_fp[0][ix - NI] = wr_data[p*XL +: XL];
            if (ix - NI != ZI) m_fp[1][ix - NI] = wr_data[p*XL +: XL];
          end
        end
      end
    end
  endtask

  // Inputs are set just after a falling edge; outputs checked 1 ns later
  task automatic cycle(input string tag);
    #1;
    if (!rst) check_all(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic set_rd(input int p, input int ix, input int kd);
    rd_idx[p*IW +: IW] = IW'(ix);
    rd_kind[p*2 +: 2]  = 2'(kd);
  endtask

  task automatic set_wr(input int p, input bit en, input int ix, input int kd,
                        input logic [XL-1:0] dat);
    wr_en[p]             = en;
    wr_idx[p*IW +: IW]   = IW'(ix);
    wr_kind[p*2 +: 2]    = 2'(kd);
    wr_data[p*XL +: XL]  = dat;
  endtask

  task automatic idle_wr();
    wr_en = '0;
  endtask

  function automatic int pick_kind(input int ix);
    int r;
    r = int'($urandom % 10);
    if (r == 0) return 3;
    if (r == 1) return (ix < NI) ? 1 : 0;
    if (ix < NI) return 0;
    return 1 + int'($urandom % 2);
  endfunction

  initial begin
    #(200000 * 8);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired t=%0t got=hung exp=done", $time);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    cycle("R9");
    cycle("R9");
    rst = 1'b0;
    // R9: all entries zero after reset
    set_rd(0, 5, 0); set_rd(1, NI + 3, 2);
    cycle("R9 reset clear");

    // R1 sweep of classification
    for (int i = 0; i < 64; i++) begin
      cls_idx = IW'(i);
      cycle("R1 sweep");
    end

    // R5: same-cycle read sees old, next cycle new
    set_wr(0, 1, 3, 0, 64'hA5A5_0000_1111_2222);
    set_rd(0, 3, 0);
    cycle("R5 same cycle old");
    idle_wr();
    cycle("R5 next cycle new");

    // R4: write by value, read raw bits; write raw bits, read value
    set_wr(0, 1, NI + 2, 1, 64'h4009_21FB_5444_2D18);
    set_wr(1, 1, NI + 7, 2, 64'hDEAD_BEEF_0BAD_F00D);
    cycle("R4 write");
    idle_wr();
    set_rd(0, NI + 2, 2); set_rd(1, NI + 7, 1);
    cycle("R4 view alias");

    // R6: integer zero register
    set_wr(1, 1, ZI, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    set_rd(0, ZI, 0);
    cycle("R6 zero write");
    idle_wr();
    cycle("R6 zero reads zero");

    // R7: floating-point zero offset per variant
    set_wr(0, 1, NI + ZI, 2, 64'h1234_5678_9ABC_DEF0);
    set_rd(1, NI + ZI, 1);
    cycle("R7 fp zero write");
    idle_wr();
    cycle("R7 fp zero read");

    // R8: both ports write one entry; port 1 wins
    set_wr(0, 1, 7, 0, 64'h0000_0000_0000_00D0);
    set_wr(1, 1, 7, 0, 64'h0000_0000_0000_00D1);
    cycle("R8 collide");
    idle_wr();
    set_rd(0, 7, 0);
    cycle("R8 winner");

    // R3: erroneous writes store nothing
    set_wr(0, 1, 3, 1, 64'h1111_1111_1111_1111);
    set_wr(1, 1, 50, 0, 64'h2222_2222_2222_2222);
    cycle("R3 bad write");
    set_wr(0, 1, NI + 2, 0, 64'h3333_3333_3333_3333);
    set_wr(1, 1, NI + 7, 3, 64'h4444_4444_4444_4444);
    cycle("R3 bad write fp");
    idle_wr();
    set_rd(0, 3, 0); set_rd(1, NI + 2, 1);
    cycle("R3 unchanged");
    set_rd(0, NI + 7, 2); set_rd(1, 3, 2);
    cycle("R3 unchanged/err read");

    // R10: independent read ports
    set_rd(0, NI + 2, 1); set_rd(1, 3, 0);
    cycle("R10 ports");
    set_rd(0, 7, 0); set_rd(1, NI + 7, 2);
    cycle("R10 ports swap");

    // Random traffic over a narrow window
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < NW; p++) begin
        int ix;
        ix = (($urandom % 8) == 0) ? int'($urandom % 64)
           : ((($urandom % 2) == 0) ? int'($urandom % 4) : NI + int'($urandom % 4));
        set_wr(p, ($urandom % 3) != 0, ix, pick_kind(ix), {$urandom, $urandom});
      end
      for (int p = 0; p < NR; p++) begin
        int ix;
        ix = (($urandom % 8) == 0) ? int'($urandom % 64)
           : ((($urandom % 2) == 0) ? int'($urandom % 4) : NI + int'($urandom % 4));
        set_rd(p, ix, pick_kind(ix));
      end
      cls_idx = IW'($urandom % 64);
      cycle("R5 random");
    end
    idle_wr();

    // R9: reset again mid-run
    rst = 1'b1;
    cycle("R9");
    rst = 1'b0;
    set_rd(0, 1, 0); set_rd(1, NI + 1, 1);
    cycle("R9 reset again");
    set_rd(0, 2, 0); set_rd(1, NI + 3, 2);
    cycle("R9 reset again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule